// File: doc/BRIEF.md
# Two-Group Cascaded DMA Channel Priority Arbiter

This block decides which of eight DMA channel positions is served next. The channels form two priority groups. The low group holds channels 0 to 3. The high group holds channels 5 to 7, and its slot 4 acts as a cascade link that stands for the whole low group. A channel asks for service in either of two ways: through its hardware request line, or through a software request bit that stays set until the channel reaches terminal count. A per-channel mask blocks both kinds of request. Each group has its own mode input that selects fixed order or rotating order.

The arbiter is a two-state machine. In `ARB_IDLE` it evaluates all pending requests. When at least one is pending, it takes the `IDLE->BUSY` transition and registers a one-hot grant together with the winner's number. In `ARB_BUSY` it holds that grant unchanged until the service-end strobe arrives. It then takes the `BUSY->IDLE` transition, drops the grant and records the served position in each group's rotation pointer. A service-end strobe that comes with terminal count also clears the served channel's software request bit. Bus timing and address generation belong to other blocks.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While reset is held and after it is released, `grant` is 0, `grant_valid` is 0 and `grant_ch` is 0. Both rotation pointers reset to group position 3, so position 0 of each group has the highest priority in rotating mode.
- R2: `grant` has at most one bit set. `grant_valid` is 1 exactly when `grant` is nonzero. When valid, `grant_ch` is the index of the set bit.
- R3: In `ARB_IDLE`, if any request is pending at a clock edge, the grant appears at that edge. The grant then stays unchanged on every edge where `done` is 0. An edge where `done` is 1 clears it, and the earliest next grant comes one edge later.
- R4: With `rot_lo`=0, the lowest-numbered pending channel among 0 to 3 wins within the low group.
- R5: The high group orders its slots 4, 5, 6, 7. Slot 4 is pending when any unmasked channel 0 to 3 is pending. With `rot_hi`=0, a pending low-group channel therefore beats channels 5 to 7. When slot 4 wins, the grant goes to the low group's winner.
- R6: In rotating mode (`rot_lo`=1 or `rot_hi`=1), the search starts at the position after that group's pointer and wraps modulo 4. Each completed service (`done` in `ARB_BUSY`) sets the pointer, so the served position becomes the lowest priority.
- R7: When a low-group channel completes, the high-group pointer is set to slot 4 (position 0). When channel 5 to 7 completes, it is set to that channel minus 4. Both pointers update whatever the mode inputs are.
- R8: Channel 4 is never granted. `dreq[4]`, `sw_req_set[4]` and `mask[4]` have no effect on any grant.
- R9: A channel whose `mask` bit is 1 is never granted. This holds whether its request comes from `dreq` or from its software bit.
- R10: A 1 on `sw_req_set[c]` sets the software request bit for channel c. That bit joins arbitration from the next edge and acts exactly like `dreq[c]`.
- R11: The software bit of the granted channel is cleared by `done` together with `tc`. `done` without `tc` leaves it set. A set on the same edge wins over the clear.
- R12: `done` and `tc` in `ARB_IDLE` have no effect on grants, pointers or software bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq | input | 8 | Hardware request line per channel |
| sw_req_set | input | 8 | Per-channel strobe that sets the software request bit |
| mask | input | 8 | Per-channel mask; 1 blocks the channel |
| rot_lo | input | 1 | Low group mode: 0 fixed, 1 rotating |
| rot_hi | input | 1 | High group mode: 0 fixed, 1 rotating |
| done | input | 1 | Current service ends on this edge |
| tc | input | 1 | Terminal count, qualified by done |
| grant | output | 8 | One-hot grant |
| grant_valid | output | 1 | A grant is active |
| grant_ch | output | 3 | Number of the granted channel |

## Verification
Several patterns drive the arbitration. Mixed requests in both groups under fixed order separate the lowest-number rule from cascade precedence. Requests on channel 4 alone, and a channel 4 mask, show that the cascade slot is never granted directly. Saturated requests under rotating mode, first in the low group and then in the high group, step the pointers through a full wrap; fixed-order logic and a pointer stuck after one service both produce a different order. Software bits are set, masked, kept by a service end without terminal count and cleared by one with it, which separates the clear rule from the set rule. Stray service-end strobes in idle show that pointers and software bits hold.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dma_grp_pick.sv
module dma_grp_pick #(
    parameter int GN = 4,
    localparam int GW = $clog2(GN)
) (
    input  logic [GN-1:0] req,
    input  logic          rotate,
    input  logic [GW-1:0] last,
    output logic          any,
    output logic [GW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = 0; k < GN; k++) begin
            logic [GW-1:0] pos;
            pos = rotate ? GW'(last + GW'(k) + GW'(1)) : GW'(k);
            if (!any && req[pos]) begin
                any = 1'b1;
                idx = pos;
            end
        end
    end
endmodule

// File: rtl/dma_swreq_bank.sv
module dma_swreq_bank #(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set,
    input  logic           clr_en,
    input  logic [CW-1:0]  clr_idx,
    output logic [NCH-1:0] q
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q[c] <= 1'b0;
                else if (set[c])
                    q[c] <= 1'b1;
                else if (clr_en && clr_idx == CW'(c))
                    q[c] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dma_arb_pkg::*;
#(
    parameter int GRP_CH = 4,
    localparam int NCH = 2 * GRP_CH,
    localparam int GW  = $clog2(GRP_CH),
    localparam int CHW = GW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] dreq,
    input  logic [NCH-1:0] sw_req_set,
    input  logic [NCH-1:0] mask,
    input  logic           rot_lo,
    input  logic           rot_hi,
    input  logic           done,
    input  logic           tc,
    output logic [NCH-1:0] grant,
    output logic           grant_valid,
    output logic [CHW-1:0] grant_ch
);
    arb_state_e state, state_nx;

    logic [NCH-1:0]    sw_q;
    logic [NCH-1:0]    eff;
    logic [GRP_CH-1:0] hi_req;
    logic [GW-1:0]     lo_last, hi_last;
    logic [GW-1:0]     lo_idx, hi_idx;
    logic              lo_any, hi_any;
    logic [CHW-1:0]    win_ch;
    logic              svc_end;
    logic              cascade_unused;

    assign eff            = (dreq | sw_q) & ~mask;
    assign cascade_unused = eff[GRP_CH];
    assign hi_req         = {eff[NCH-1:GRP_CH+1], lo_any};
    assign svc_end        = (state == ARB_BUSY) && done;
    assign win_ch         = (hi_idx == '0) ? {1'b0, lo_idx} : {1'b1, hi_idx};

    dma_grp_pick #(.GN(GRP_CH)) u_lo_pick (
        .req(eff[GRP_CH-1:0]), .rotate(rot_lo), .last(lo_last),
        .any(lo_any), .idx(lo_idx)
    );

    dma_grp_pick #(.GN(GRP_CH)) u_hi_pick (
        .req(hi_req), .rotate(rot_hi), .last(hi_last),
        .any(hi_any), .idx(hi_idx)
    );

    dma_swreq_bank #(.NCH(NCH)) u_swreq (
        .clk(clk), .rst_n(rst_n), .set(sw_req_set),
        .clr_en(svc_end && tc), .clr_idx(grant_ch), .q(sw_q)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ARB_IDLE: if (hi_any) state_nx = ARB_BUSY;
            ARB_BUSY: if (done)   state_nx = ARB_IDLE;
            default:              state_nx = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ARB_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant    <= '0;
            grant_ch <= '0;
        end else if (state == ARB_IDLE && hi_any) begin
            grant    <= NCH'(1) << win_ch;
            grant_ch <= win_ch;
        end else if (svc_end) begin
            grant    <= '0;
        end
    end

    assign grant_valid = (state == ARB_BUSY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_last <= '1;
            hi_last <= '1;
        end else if (svc_end) begin
            if (!grant_ch[GW]) begin
                lo_last <= grant_ch[GW-1:0];
                hi_last <= '0;
            end else begin
                hi_last <= grant_ch[GW-1:0];
            end
        end
    end

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_valid == (grant != '0)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !done) |=> ($stable(grant) && $stable(grant_ch)));

    assert_no_cascade_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !grant[GRP_CH]);

    assert_pending_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> ((($past(dreq) | $past(sw_q)) & ~$past(mask) & grant) != '0));

    assert_sw_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_end && tc && !sw_req_set[grant_ch]) |=> !sw_q[$past(grant_ch)]);

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        svc_end |=> !grant_valid);
endmodule

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dreq = '0, sw_req_set = '0, mask = '0;
    logic       rot_lo = 1'b0, rot_hi = 1'b0, done = 1'b0, tc = 1'b0;
    logic [7:0] grant;
    logic       grant_valid;
    logic [2:0] grant_ch;

    int n_chk = 0, n_fail = 0, cyc_cnt = 0;

    // behavioural model state
    bit m_busy;
    int m_ch;
    bit [7:0] m_sw;
    int m_lo_last, m_hi_last;

    always #10 clk = ~clk;

    dma_prio_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .sw_req_set(sw_req_set),
        .mask(mask), .rot_lo(rot_lo), .rot_hi(rot_hi), .done(done), .tc(tc),
        .grant(grant), .grant_valid(grant_valid), .grant_ch(grant_ch)
    );

    function automatic int pick4(bit [3:0] r, bit rot, int last);
        for (int k = 0; k < 4; k++) begin
            int p;
            p = rot ? (last + 1 + k) % 4 : k;
            if (r[p]) return p;
        end
        return -1;
    endfunction

    task automatic model_edge();
        bit [7:0] e;
        int lo, h;
        for (int c = 0; c < 8; c++) e[c] = (dreq[c] | m_sw[c]) & ~mask[c];
        if (m_busy && done && tc) m_sw[m_ch] = 1'b0;
        m_sw = m_sw | sw_req_set;
        if (!m_busy) begin
            lo = pick4(e[3:0], rot_lo, m_lo_last);
            h  = pick4({e[7:5], lo >= 0}, rot_hi, m_hi_last);
            if (h >= 0) begin
                m_busy = 1'b1;
                m_ch = (h == 0) ? lo : 4 + h;
            end
        end else if (done) begin
            if (m_ch < 4) begin m_lo_last = m_ch; m_hi_last = 0; end
            else m_hi_last = m_ch - 4;
            m_busy = 1'b0;
        end
    endtask

    task automatic compare(string tag);
        bit [7:0] eg;
        eg = m_busy ? (8'd1 << m_ch) : 8'd0;
        n_chk++;
        if (grant !== eg || grant_valid !== m_busy || (m_busy && grant_ch !== 3'(m_ch))) begin
            n_fail++;
            $display("FAIL %s: grant=%b valid=%0b ch=%0d expected grant=%b valid=%0b ch=%0d",
                     tag, grant, grant_valid, grant_ch, eg, m_busy, m_ch);
        end
    endtask

    // one clock: apply current inputs, update model, check, clear strobes
    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
        sw_req_set = '0;
        done = 1'b0;
        tc = 1'b0;
    endtask

    task automatic finish_svc(string tag, bit with_tc);
        done = 1'b1;
        tc = with_tc;
        tick(tag);
    endtask

    // expect a specific channel (on top of the model comparison)
    task automatic expect_ch(string tag, int ch);
        n_chk++;
        if (!grant_valid || grant_ch !== 3'(ch)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b ch=%0d expected ch=%0d", tag, grant_valid, grant_ch, ch);
        end
    endtask

    initial begin
        m_busy = 0; m_ch = 0; m_sw = '0; m_lo_last = 3; m_hi_last = 3;
        repeat (3) @(negedge clk);
        n_chk++;
        if (grant !== 8'd0 || grant_valid !== 1'b0 || grant_ch !== 3'd0) begin
            n_fail++;
            $display("FAIL R1: grant=%b valid=%0b ch=%0d expected 0/0/0", grant, grant_valid, grant_ch);
        end
        rst_n = 1'b1;
        tick("R1");

        // R4 R5: fixed order, low group beats high group via slot 4
        dreq = 8'b1110_0110;
        tick("R4"); expect_ch("R4", 1);
        tick("R3"); tick("R3"); expect_ch("R3", 1);
        finish_svc("R3", 0);
        dreq = 8'b1110_0000;
        tick("R5"); expect_ch("R5", 5);
        finish_svc("R5", 0);
        dreq = 8'b1100_0000;
        tick("R5"); expect_ch("R5", 6);
        finish_svc("R5", 0);

        // R8: channel 4 request alone never granted; mask[4] has no effect
        dreq = 8'b0001_0000; sw_req_set = 8'b0001_0000;
        tick("R8"); tick("R8"); tick("R8");
        dreq = 8'b0000_1000; mask = 8'b0001_0000;
        tick("R8"); expect_ch("R8", 3);
        finish_svc("R8", 1);
        mask = '0; dreq = '0;
        tick("R8");

        // R9: masked hardware request skipped
        dreq = 8'b1000_0110; mask = 8'b0000_0010;
        tick("R9"); expect_ch("R9", 2);
        finish_svc("R9", 0);
        mask = 8'b0000_0110;
        tick("R9"); expect_ch("R9", 7);
        finish_svc("R9", 0);
        dreq = '0; mask = '0;
        tick("R9");

        // R10 R11: software requests
        sw_req_set = 8'b0100_0000;
        tick("R10");
        tick("R10"); expect_ch("R10", 6);
        finish_svc("R11", 0);
        tick("R11"); expect_ch("R11", 6);
        finish_svc("R11", 1);
        tick("R11"); tick("R11");
        sw_req_set = 8'b0000_0100; mask = 8'b0000_0100;
        tick("R9"); tick("R9"); tick("R9");
        mask = '0;
        tick("R10"); expect_ch("R10", 2);
        sw_req_set = 8'b0000_0100;
        finish_svc("R11", 1);
        tick("R11"); expect_ch("R11", 2);
        finish_svc("R11", 1);
        tick("R11");

        // R6: rotating low group
        rot_lo = 1'b1; dreq = 8'b0000_1111;
        for (int i = 0; i < 6; i++) begin
            tick("R6"); finish_svc("R6", 0);
        end
        // R7: rotating high group with slot 4 in rotation
        rot_hi = 1'b1; dreq = 8'b1110_0001;
        for (int i = 0; i < 6; i++) begin
            tick("R7"); finish_svc("R7", 0);
        end
        dreq = '0;
        // R12: stray done/tc in idle ignored
        done = 1'b1; tc = 1'b1; tick("R12");
        done = 1'b1; tc = 1'b1; tick("R12");
        dreq = 8'b1110_0011;
        for (int i = 0; i < 4; i++) begin
            tick("R12"); finish_svc("R12", 0);
        end
        rot_lo = 1'b0; rot_hi = 1'b0;
        tick("R4"); finish_svc("R4", 0);
        dreq = '0;
        tick("R2");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cyc_cnt);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule